// File: doc/BRIEF.md
# Dual-Channel Serial DAC Register Front End

This block is the digital side of a two-channel digital-to-analog converter. A host writes words over a three-wire serial link. The link has a data line, a serial clock and an active-low select. Each word carries a two-bit channel address followed by a data code. The address sends the code to the input register of channel A, of channel B, of both, or of neither. A load-control pin then moves the input registers into the output (DAC) registers. While that pin is low the output registers follow the input registers. While it is high they hold their value.

A separate active-low clear pin forces all four registers to zero or to midscale, as chosen by a level-select pin. All pins are asynchronous to the system clock. Each pin passes through a two-flop synchronizer, and its edges are detected in the system clock domain, so every register runs on one clock. The data width `DW` is a parameter; 16 and 14 are the intended values. The two output codes are registered.

Top module: `dual_dac_frontend`

## Requirements
- R1: A frame is DW+2 bits sent most significant bit first: address bit 1, then address bit 0, then data bits DW-1 down to 0. Each bit is taken on a rising edge of the serial clock.
- R2: The shift register advances only on serial clock rising edges that occur while select is low. Serial clock edges while select is high change no state.
- R3: On a rising edge of select, only the last DW+2 bits shifted in are decoded, and earlier bits are ignored. A shorter frame still loads, and bits left from earlier traffic fill its missing high positions.
- R4: The address decodes as follows. 2'b00 writes no input register. 2'b01 writes channel A, 2'b10 writes channel B, and 2'b11 writes both channels with the same code.
- R5: While load-control is low, each DAC register takes the same value as its input register on the same clock edge.
- R6: While load-control is high, the DAC registers hold their value. A rising edge of load-control latches the current input register contents.
- R7: While clear is low and level-select is 0, all four registers are forced to zero.
- R8: While clear is low and level-select is 1, all four registers are forced to midscale, which is only bit DW-1 set (8000h when DW is 16).
- R9: The synchronous system reset `rst` sets all four registers to zero.
- R10: Clear overrides a serial load or load-control event that happens in the same cycle. A load whose strobe falls inside the clear window is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset (power-up state) |
| sclk_in | input | 1 | Serial clock pin |
| csn_in | input | 1 | Active-low frame select pin |
| sdi_in | input | 1 | Serial data pin |
| ldctl_in | input | 1 | Load-control pin: low is transparent, high holds |
| clrn_in | input | 1 | Active-low clear pin |
| mid_sel | input | 1 | Clear level select: 0 zero, 1 midscale |
| dac_a_code | output | DW | Channel A DAC register |
| dac_b_code | output | DW | Channel B DAC register |

## Verification
On every cycle the assertions check several properties. The shift register stays still while the synchronized select is high. Address 00 leaves both input registers untouched. The DAC registers match the input registers while transparent and hold steady while load-control stays high. A clear or a system reset drives each register to its forced level. Other behaviour only shows over a whole pin sequence, so the bench scenarios have to cover it. That includes MSB-first framing and keeping only the last DW+2 bits of a long frame. It also includes stale bits filling a short frame and both channels receiving one code. The last is a load lost because it arrived together with a clear.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
  typedef enum logic [1:0] {
    ADR_NONE = 2'b00,
    ADR_A    = 2'b01,
    ADR_B    = 2'b10,
    ADR_BOTH = 2'b11
  } dac_adr_e;

  localparam int NUM_CH   = 2;
  localparam int ADR_BITS = 2;
endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= RST_VAL;
      q_sync <= RST_VAL;
    end else begin
      meta_q <= d_async;
      q_sync <= meta_q;
    end
  end
endmodule

// File: rtl/dacfe_shift.sv
module dacfe_shift #(
  parameter int FW = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          shift_en,
  input  logic          bit_in,
  output logic [FW-1:0] sr_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q <= '0;
    end else if (shift_en) begin
      sr_q <= {sr_q[FW-2:0], bit_in};
    end
  end
endmodule

// File: rtl/dacfe_chan.sv
module dacfe_chan #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_act,
  input  logic [DW-1:0] clr_val,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          ld_s,
  input  logic          ld_rise,
  output logic [DW-1:0] in_q,
  output logic [DW-1:0] dac_q
);
  logic [DW-1:0] in_nxt;
  logic [DW-1:0] dac_nxt;

  always_comb begin
    if (clr_act)    in_nxt = clr_val;
    else if (wr_en) in_nxt = wr_data;
    else            in_nxt = in_q;
  end

  always_comb begin
    if (clr_act)      dac_nxt = clr_val;
    else if (!ld_s)   dac_nxt = in_nxt;
    else if (ld_rise) dac_nxt = in_q;
    else              dac_nxt = dac_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_q  <= '0;
      dac_q <= '0;
    end else begin
      in_q  <= in_nxt;
      dac_q <= dac_nxt;
    end
  end
endmodule

// File: rtl/dual_dac_frontend.sv
module dual_dac_frontend
  import dacfe_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sclk_in,
  input  logic          csn_in,
  input  logic          sdi_in,
  input  logic          ldctl_in,
  input  logic          clrn_in,
  input  logic          mid_sel,
  output logic [DW-1:0] dac_a_code,
  output logic [DW-1:0] dac_b_code
);
  localparam int            FW      = DW + ADR_BITS;
  localparam int            NPIN    = 6;
  localparam logic [DW-1:0] MID_VAL = {1'b1, {(DW-1){1'b0}}};
  // pin order: mid, clrn, ld, sdi, csn, sclk ; idle levels on reset
  localparam logic [NPIN-1:0] PIN_IDLE = 6'b010010;

  logic [NPIN-1:0] pins_s;
  logic sclk_s, csn_s, sdi_s, ld_s, clrn_s, mid_s;
  logic sclk_q, csn_q, ld_q;
  logic shift_en, load_stb, ld_rise, clr_act;
  logic [DW-1:0] clr_val;
  logic [FW-1:0] sr;
  dac_adr_e      frame_addr;
  logic [DW-1:0] frame_data;
  logic [NUM_CH-1:0][DW-1:0] in_q;
  logic [NUM_CH-1:0][DW-1:0] dac_q;

  dacfe_sync #(.W(NPIN), .RST_VAL(PIN_IDLE)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async ({mid_sel, clrn_in, ldctl_in, sdi_in, csn_in, sclk_in}),
    .q_sync  (pins_s)
  );

  assign {mid_s, clrn_s, ld_s, sdi_s, csn_s, sclk_s} = pins_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= 1'b0;
      csn_q  <= 1'b1;
      ld_q   <= 1'b0;
    end else begin
      sclk_q <= sclk_s;
      csn_q  <= csn_s;
      ld_q   <= ld_s;
    end
  end

  assign shift_en = sclk_s & ~sclk_q & ~csn_s;
  assign load_stb = csn_s & ~csn_q;
  assign ld_rise  = ld_s & ~ld_q;
  assign clr_act  = ~clrn_s;
  assign clr_val  = mid_s ? MID_VAL : '0;

  dacfe_shift #(.FW(FW)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .shift_en (shift_en),
    .bit_in   (sdi_s),
    .sr_q     (sr)
  );

  assign frame_addr = dac_adr_e'(sr[FW-1 -: ADR_BITS]);
  assign frame_data = sr[DW-1:0];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dacfe_chan #(.DW(DW)) u_chan (
      .clk     (clk),
      .rst     (rst),
      .clr_act (clr_act),
      .clr_val (clr_val),
      .wr_en   (load_stb & frame_addr[c]),
      .wr_data (frame_data),
      .ld_s    (ld_s),
      .ld_rise (ld_rise),
      .in_q    (in_q[c]),
      .dac_q   (dac_q[c])
    );
  end

  assign dac_a_code = dac_q[0];
  assign dac_b_code = dac_q[1];
endmodule

// File: rtl/dacfe_checker.sv
module dacfe_checker #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          clr_act,
  input logic          mid_s,
  input logic          ld_s,
  input logic          ld_q,
  input logic          load_stb,
  input logic [1:0]    addr,
  input logic [DW+1:0] sr,
  input logic          csn_s,
  input logic [DW-1:0] in_a,
  input logic [DW-1:0] in_b,
  input logic [DW-1:0] dac_a,
  input logic [DW-1:0] dac_b
);
  localparam logic [DW-1:0] MID_VAL = {1'b1, {(DW-1){1'b0}}};

  AST_SHIFT_GATED: assert property (@(posedge clk) disable iff (rst)
    csn_s |=> $stable(sr)) else $error("shift with select high"); // R2

  AST_ADDR_NONE: assert property (@(posedge clk) disable iff (rst)
    (load_stb && addr == 2'b00 && !clr_act) |=> ($stable(in_a) && $stable(in_b)))
    else $error("address 00 wrote a channel"); // R4

  AST_TRANSPARENT: assert property (@(posedge clk) disable iff (rst)
    (!ld_s && !clr_act) |=> (dac_a == in_a && dac_b == in_b))
    else $error("dac not following input"); // R5

  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ld_s && ld_q && !clr_act) |=> ($stable(dac_a) && $stable(dac_b)))
    else $error("dac changed while held"); // R6

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (clr_act && !mid_s) |=> (in_a == '0 && in_b == '0 && dac_a == '0 && dac_b == '0))
    else $error("clear to zero failed"); // R7

  AST_CLEAR_MID: assert property (@(posedge clk) disable iff (rst)
    (clr_act && mid_s) |=> (in_a == MID_VAL && in_b == MID_VAL && dac_a == MID_VAL && dac_b == MID_VAL))
    else $error("clear to midscale failed"); // R8

  AST_SYS_RESET: assert property (@(posedge clk)
    rst |=> (dac_a == '0 && dac_b == '0 && in_a == '0 && in_b == '0))
    else $error("system reset state wrong"); // R9
endmodule

bind dual_dac_frontend dacfe_checker #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .clr_act  (clr_act),
  .mid_s    (mid_s),
  .ld_s     (ld_s),
  .ld_q     (ld_q),
  .load_stb (load_stb),
  .addr     (frame_addr),
  .sr       (sr),
  .csn_s    (csn_s),
  .in_a     (in_q[0]),
  .in_b     (in_q[1]),
  .dac_a    (dac_a_code),
  .dac_b    (dac_b_code)
);

// File: tb/dual_dac_frontend_test.sv
module dual_dac_frontend_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int FW = DW + 2;
  localparam logic [DW-1:0] MID = 16'h8000;
  localparam int NVEC = 10;
  // {hold, len[5:0], word[23:0]}
  localparam logic [30:0] VEC [NVEC] = '{
    {1'b0, 6'd18, 24'h011234},
    {1'b0, 6'd18, 24'h02ABCD},
    {1'b0, 6'd18, 24'h035A5A},
    {1'b0, 6'd18, 24'h00FFFF},
    {1'b1, 6'd18, 24'h010F0F},
    {1'b1, 6'd18, 24'h027777},
    {1'b0, 6'd22, 24'h3D2468},
    {1'b0, 6'd10, 24'h0003C5},
    {1'b0, 6'd18, 24'h030000},
    {1'b1, 6'd18, 24'h03FFFF}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk_in = 1'b0, csn_in = 1'b1, sdi_in = 1'b0;
  logic ldctl_in = 1'b0, clrn_in = 1'b1, mid_sel = 1'b0;
  logic [DW-1:0] dac_a_code, dac_b_code;

  int checks = 0;
  int errors = 0;
  logic [FW-1:0] m_sr = '0;
  logic [DW-1:0] m_in [2] = '{'0, '0};
  logic [DW-1:0] m_dac [2] = '{'0, '0};
  logic m_ld = 1'b0;

  dual_dac_frontend #(.DW(DW)) uut (
    .clk(clk), .rst(rst), .sclk_in(sclk_in), .csn_in(csn_in), .sdi_in(sdi_in),
    .ldctl_in(ldctl_in), .clrn_in(clrn_in), .mid_sel(mid_sel),
    .dac_a_code(dac_a_code), .dac_b_code(dac_b_code)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic step();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic follow();
    if (!m_ld) begin
      m_dac[0] = m_in[0];
      m_dac[1] = m_in[1];
    end
  endtask

  task automatic check_dacs(string tag);
    checks++;
    if (dac_a_code !== m_dac[0]) begin
      errors++;
      $display("FAIL %s chA got %h exp %h", tag, dac_a_code, m_dac[0]);
    end
    checks++;
    if (dac_b_code !== m_dac[1]) begin
      errors++;
      $display("FAIL %s chB got %h exp %h", tag, dac_b_code, m_dac[1]);
    end
  endtask

  task automatic clk_bit(logic b);
    sdi_in = b; step();
    sclk_in = 1'b1; step();
    if (!csn_in) m_sr = {m_sr[FW-2:0], b};
    sclk_in = 1'b0; step();
  endtask

  task automatic cs_low();
    csn_in = 1'b0; step();
  endtask

  task automatic cs_high();
    csn_in = 1'b1; step();
    if (m_sr[FW-2]) m_in[0] = m_sr[DW-1:0];
    if (m_sr[FW-1]) m_in[1] = m_sr[DW-1:0];
    follow();
  endtask

  task automatic set_ld(logic v);
    ldctl_in = v; step();
    m_ld = v;
    follow();
  endtask

  task automatic send(logic [23:0] word, int len);
    cs_low();
    for (int i = len - 1; i >= 0; i--) clk_bit(word[i]);
    cs_high();
  endtask

  task automatic do_clear(logic mid);
    mid_sel = mid; clrn_in = 1'b0; step();
    for (int c = 0; c < 2; c++) begin
      m_in[c] = mid ? MID : '0;
      m_dac[c] = mid ? MID : '0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    step();
    check_dacs("R9 reset state");

    // table-driven frames: R1 framing, R3 length, R4 decode, R5/R6 load control
    for (int v = 0; v < NVEC; v++) begin
      logic hold;
      logic [5:0] len;
      logic [23:0] word;
      {hold, len, word} = VEC[v];
      if (hold) set_ld(1'b1);
      send(word, int'(len));
      if (hold) begin
        check_dacs($sformatf("R6 hold vec%0d", v));
        set_ld(1'b0);
        check_dacs($sformatf("R5 release vec%0d", v));
      end else begin
        check_dacs($sformatf("R1 R3 R4 R5 vec%0d", v));
      end
    end

    // R2: serial clocks with select high must not shift
    send(24'h03_4321, 18);
    check_dacs("R4 both pre R2");
    for (int k = 0; k < 6; k++) clk_bit(1'b1);
    cs_low();
    cs_high();
    check_dacs("R2 reload unchanged frame");

    // R6: rising load-control latches, then later frame is held
    set_ld(1'b1);
    send(24'h01_0101, 18);
    check_dacs("R6 held after latch");
    set_ld(1'b0);
    check_dacs("R5 follow after hold");

    // R7 / R8 clear levels
    do_clear(1'b0);
    check_dacs("R7 clear zero");
    clrn_in = 1'b1; step();
    check_dacs("R7 after release");
    do_clear(1'b1);
    check_dacs("R8 clear midscale");
    clrn_in = 1'b1; step();
    check_dacs("R8 after release");

    // R10: load strobe together with clear is lost
    cs_low();
    for (int i = 17; i >= 0; i--) clk_bit(1'(24'h03_1111 >> i));
    mid_sel = 1'b0; csn_in = 1'b1; clrn_in = 1'b0; step();
    for (int c = 0; c < 2; c++) begin
      m_in[c] = '0; m_dac[c] = '0;
    end
    check_dacs("R10 clear wins");
    step();
    check_dacs("R10 clear held");
    clrn_in = 1'b1; step();
    check_dacs("R10 load lost");

    // R9 again: system reset mid-run
    send(24'h02_9999, 18);
    check_dacs("R4 chB before reset");
    rst = 1'b1; step();
    rst = 1'b0; step();
    m_in[0] = '0; m_in[1] = '0; m_dac[0] = '0; m_dac[1] = '0;
    check_dacs("R9 reset after traffic");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule